// File: doc/BRIEF.md
# Pin-Triggered Conversion Sequencer

This block sequences a self-clocked two-channel converter core that is started by one external convert pin. A rising edge on the pin wakes the core from shutdown. The later falling edge closes the track/hold and starts a conversion. When the conversion time has run out, the block writes the core's output into a result register together with a channel tag and a validity flag, and then returns the core to shutdown. The pin must have stayed high for the full power-up time, or the stored result is flagged invalid.

All timing comes from a free-running tick, which models the on-chip oscillator. The power-up and conversion times are parameters counted in ticks. The pin has effect only when the cycle-timer value and the four command bits are all zero, and only while no serial transfer is running. When both channel enables are set, the block alternates between the two channels on successive pulses.

Top module: `pin_conv_seq`

## Requirements
- R1: After reset, the power enable, the hold output, the start pulse and the result write are low, the channel select is 0, and the stored result has channel 0, data 0 and the validity flag clear.
- R2: When the block is in shutdown, a rising edge on `convst_i` with the mode active and `serial_busy_i` low raises `pwr_en_o` at the next clock.
- R3: A falling edge accepted after at least `PWRUP_TICKS` ticks have elapsed since the rising edge yields a stored result with `res_valid_o` = 1.
- R4: A falling edge during power-up raises `hold_o` at the next clock, together with a `conv_start_o` pulse that lasts one cycle.
- R5: A conversion ends on its `CONV_TICKS`-th tick. In the same cycle, `res_we_o` pulses for one cycle and `hold_o` and `pwr_en_o` return low.
- R6: If the pin falls before `PWRUP_TICKS` ticks have elapsed, a conversion still runs, but the stored result has `res_valid_o` = 0.
- R7: The mode is active only when `cyc_timer_i` is zero and `cmd_i` is 4'b0000. Otherwise a rising edge leaves the block in shutdown.
- R8: The channel is chosen on the accepted rising edge and held until the conversion ends. The enable value 2'b01 selects channel 0, 2'b10 selects channel 1 and 2'b00 selects channel 0. With 2'b11, the channel is the opposite of the one used by the last completed conversion, and it is 0 after reset.
- R9: A rising edge while `serial_busy_i` is high leaves the block in shutdown.
- R10: The result outputs (`res_chan_o`, `res_data_o`, `res_valid_o`) change only on a completion cycle. They then carry the converted channel and the `adc_data_i` value sampled in that cycle.
- R11: Pin edges during a conversion are ignored. The conversion completes with exactly one result write, and the block then sits in shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convst_i | input | 1 | Synchronised convert pin |
| serial_busy_i | input | 1 | Serial read or write in progress |
| cyc_timer_i | input | TMR_W | Cycle-timer register value |
| cmd_i | input | 4 | Command bits |
| chan_en_i | input | 2 | Channel enables (bit 0 = channel 0, bit 1 = channel 1) |
| adc_data_i | input | DATA_W | Conversion value from the core |
| pwr_en_o | output | 1 | Core power-up enable |
| hold_o | output | 1 | Track/hold in hold |
| conv_start_o | output | 1 | One-cycle conversion start |
| chan_sel_o | output | 1 | Channel being converted |
| res_we_o | output | 1 | Result register write strobe |
| res_valid_o | output | 1 | Stored result validity flag |
| res_chan_o | output | 1 | Stored result channel tag |
| res_data_o | output | DATA_W | Stored conversion value |

## Verification
Some properties are checked by assertions on every cycle:
- the start pulse is one cycle long and coincides with entry into hold;
- a result write ends the hold phase and the power enable;
- the stored result is stable outside write cycles;
- the channel select does not move while the core is powered;
- gated or busy rising edges never wake the block;
- the phase counter stays within its bound.

Other behaviour depends on how the free-running tick lines up with the pin, and only the bench's scenarios can show it. A cycle-accurate reference model covers long and short pulses, both single-channel enables, alternation with both channels enabled, each reason for gating, and pin activity during a conversion.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_PWR = 2'd1,
    ST_CNV = 2'd2
  } psq_state_e;

  // Channel choice: single enables pick their own channel, both alternate.
  function automatic logic pick_chan(input logic [1:0] en, input logic ptr);
    logic c;
    case (en)
      2'b10:   c = 1'b1;
      2'b11:   c = ptr;
      default: c = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/psq_tick.sv
module psq_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/psq_edge.sv
module psq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign rise_o = pin_i & ~pin_q;
  assign fall_o = ~pin_i & pin_q;

endmodule

// File: rtl/psq_chan.sv
module psq_chan
  import psq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_i,
  input  logic       load_i,
  input  logic       adv_i,
  output logic       chan_o
);

  logic ptr_q, ptr_d;
  logic chan_q, chan_d;

  always_comb begin
    chan_d = chan_q;
    ptr_d  = ptr_q;
    if (load_i) chan_d = pick_chan(en_i, ptr_q);
    if (adv_i)  ptr_d  = ~chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= 1'b0;
      ptr_q  <= 1'b0;
    end else begin
      if (load_i) chan_q <= chan_d;
      if (adv_i)  ptr_q  <= ptr_d;
    end
  end

  assign chan_o = chan_q;

endmodule

// File: rtl/pin_conv_seq.sv
module pin_conv_seq
  import psq_pkg::*;
#(
  parameter int TICK_DIV    = 4,
  parameter int PWRUP_TICKS = 5,
  parameter int CONV_TICKS  = 10,
  parameter int TMR_W       = 8,
  parameter int DATA_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convst_i,
  input  logic              serial_busy_i,
  input  logic [TMR_W-1:0]  cyc_timer_i,
  input  logic [3:0]        cmd_i,
  input  logic [1:0]        chan_en_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              pwr_en_o,
  output logic              hold_o,
  output logic              conv_start_o,
  output logic              chan_sel_o,
  output logic              res_we_o,
  output logic              res_valid_o,
  output logic              res_chan_o,
  output logic [DATA_W-1:0] res_data_o
);

  localparam int MAXT  = (PWRUP_TICKS > CONV_TICKS) ? PWRUP_TICKS : CONV_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] PW_DONE = CNT_W'(PWRUP_TICKS);
  localparam logic [CNT_W-1:0] CV_LAST = CNT_W'(CONV_TICKS - 1);

  logic tick, rise, fall, mode_en, accept, done;
  psq_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic vlat_q, vlat_d, start_q, start_d, we_q, we_d;
  logic [DATA_W-1:0] rdata_q;
  logic rchan_q, rvalid_q, chan;

  psq_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick_o(tick));
  psq_edge u_edge (.clk(clk), .rst_n(rst_n), .pin_i(convst_i), .rise_o(rise), .fall_o(fall));
  psq_chan u_chan (.clk(clk), .rst_n(rst_n), .en_i(chan_en_i), .load_i(accept),
                   .adv_i(done), .chan_o(chan));

  assign mode_en = (cyc_timer_i == '0) && (cmd_i == 4'b0000);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    vlat_d  = vlat_q;
    start_d = 1'b0;
    we_d    = 1'b0;
    accept  = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_OFF: begin
        if (rise && mode_en && !serial_busy_i) begin
          state_d = ST_PWR;
          cnt_d   = '0;
          accept  = 1'b1;
        end
      end
      ST_PWR: begin
        if (fall) begin
          state_d = ST_CNV;
          vlat_d  = (cnt_q == PW_DONE);
          cnt_d   = '0;
          start_d = 1'b1;
        end else if (tick && (cnt_q != PW_DONE)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CNV: begin
        if (tick) begin
          if (cnt_q == CV_LAST) begin
            state_d = ST_OFF;
            we_d    = 1'b1;
            done    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      cnt_q    <= '0;
      vlat_q   <= 1'b0;
      start_q  <= 1'b0;
      we_q     <= 1'b0;
      rdata_q  <= '0;
      rchan_q  <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vlat_q  <= vlat_d;
      start_q <= start_d;
      we_q    <= we_d;
      if (done) begin
        rdata_q  <= adc_data_i;
        rchan_q  <= chan;
        rvalid_q <= vlat_q;
      end
    end
  end

  assign pwr_en_o     = (state_q != ST_OFF);
  assign hold_o       = (state_q == ST_CNV);
  assign conv_start_o = start_q;
  assign chan_sel_o   = chan;
  assign res_we_o     = we_q;
  assign res_valid_o  = rvalid_q;
  assign res_chan_o   = rchan_q;
  assign res_data_o   = rdata_q;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) conv_start_o |=> !conv_start_o); // R4
  AST_HOLD_WITH_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(hold_o) |-> conv_start_o); // R4
  AST_WRITE_ENDS_CONV: assert property (@(posedge clk) disable iff (!rst_n) res_we_o |-> (!pwr_en_o && $past(hold_o))); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !res_we_o |-> ($stable(res_data_o) && $stable(res_chan_o) && $stable(res_valid_o))); // R10
  AST_GATED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (!pwr_en_o && (!mode_en || serial_busy_i)) |=> !pwr_en_o); // R7 R9
  AST_CHAN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (pwr_en_o && $past(pwr_en_o)) |-> $stable(chan_sel_o)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_W'(MAXT)); // R3

endmodule

// File: tb/sim_pin_conv_seq.sv
`timescale 1ns/1ps
module sim_pin_conv_seq;
  localparam int TD = 4, PW = 5, CV = 10, TW = 8, DW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic convst = 1'b0, busy = 1'b0;
  logic [TW-1:0] cyc = '0;
  logic [3:0] cmd = '0;
  logic [1:0] en = 2'b01;
  logic [DW-1:0] adc = '0;
  logic pwr, hold, start, chan, we, rvalid, rchan;
  logic [DW-1:0] rdata;

  int checks = 0, errors = 0, cycles = 0, we_cnt = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  pin_conv_seq #(.TICK_DIV(TD), .PWRUP_TICKS(PW), .CONV_TICKS(CV), .TMR_W(TW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .convst_i(convst), .serial_busy_i(busy), .cyc_timer_i(cyc),
    .cmd_i(cmd), .chan_en_i(en), .adc_data_i(adc), .pwr_en_o(pwr), .hold_o(hold),
    .conv_start_o(start), .chan_sel_o(chan), .res_we_o(we), .res_valid_o(rvalid),
    .res_chan_o(rchan), .res_data_o(rdata));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int m_state = 0, m_cnt = 0, m_div = 0;
  bit m_prev = 0, m_vl = 0, m_ptr = 0, m_chan = 0, m_start = 0, m_we = 0;
  bit m_rvalid = 0, m_rchan = 0;
  int m_rdata = 0;
  int res_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_div = 0; m_prev = 0; m_vl = 0; m_ptr = 0; m_chan = 0;
      m_start = 0; m_we = 0; m_rvalid = 0; m_rchan = 0; m_rdata = 0;
    end else begin
      bit tk, rs, fl;
      tk = (m_div == TD - 1);
      m_div = (m_div + 1) % TD;
      rs = convst && !m_prev;
      fl = !convst && m_prev;
      m_prev = convst;
      m_start = 0; m_we = 0;
      if (m_state == 0) begin
        if (rs && cyc == 0 && cmd == 0 && !busy) begin
          m_state = 1; m_cnt = 0;
          m_chan = (en == 2'b10) ? 1'b1 : (en == 2'b11) ? m_ptr : 1'b0;
        end
      end else if (m_state == 1) begin
        if (fl) begin
          m_state = 2; m_vl = (m_cnt == PW); m_cnt = 0; m_start = 1;
        end else if (tk && m_cnt != PW) m_cnt++;
      end else if (tk) begin
        if (m_cnt == CV - 1) begin
          m_state = 0; m_we = 1; m_rdata = adc; m_rchan = m_chan; m_rvalid = m_vl;
          m_ptr = !m_chan; res_q.push_back({m_rvalid, m_rchan});
        end else m_cnt++;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk(pwr == (m_state != 0), "R2 pwr_en", pwr, m_state != 0);
      chk(hold == (m_state == 2), "R4 hold", hold, m_state == 2);
      chk(start == m_start, "R4 conv_start", start, m_start);
      chk(chan == m_chan, "R8 chan_sel", chan, m_chan);
      chk(we == m_we, "R5 res_we", we, m_we);
      chk(rvalid == m_rvalid, "R6 res_valid", rvalid, m_rvalid);
      chk(rchan == m_rchan, "R10 res_chan", rchan, m_rchan);
      chk(rdata == DW'(m_rdata), "R10 res_data", rdata, m_rdata);
      if (we) we_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_run) begin
      done_run = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Pulse the pin; expect_wake tells whether the rising edge should be taken
  task automatic pulse(input int high, input int data, input bit expect_wake, input string tag);
    adc = DW'(data);
    convst = 1'b1;
    step(1);
    chk(pwr == expect_wake, tag, pwr, expect_wake);
    step(high - 1);
    convst = 1'b0;
    step(1);
    if (expect_wake) begin
      chk(hold && start, "R4 hold+start after fall", {hold, start}, 3);
    end
    step(CV * TD + 8);
  endtask

  initial begin
    int w0;
    step(3);
    chk(!pwr && !hold && !start && !we && !rvalid && !rchan && rdata == 0 && !chan,
        "R1 reset state", {pwr, hold, start, we, rvalid, rchan, chan}, 0);
    rst_n = 1'b1;
    step(3);

    en = 2'b01;
    pulse(30, 12'h5A5, 1, "R2 wake on rise");
    chk(rvalid == 1, "R3 long pulse valid", rvalid, 1);
    chk(rchan == 0 && rdata == 12'h5A5, "R10 result ch0", rdata, 12'h5A5);

    pulse(2, 12'h123, 1, "R2 wake short");
    chk(rvalid == 0, "R6 short pulse invalid", rvalid, 0);
    chk(rdata == 12'h123, "R6 conversion still ran", rdata, 12'h123);

    en = 2'b10;
    pulse(30, 12'h0F0, 1, "R2 wake ch1");
    chk(rchan == 1, "R8 enable 10 picks ch1", rchan, 1);

    en = 2'b00;
    pulse(30, 12'h00F, 1, "R2 wake none");
    chk(rchan == 0, "R8 enable 00 picks ch0", rchan, 0);

    en = 2'b11;
    for (int i = 0; i < 3; i++) begin
      bit prev;
      prev = rchan;
      pulse(30, 100 + i, 1, "R2 wake both");
      chk(rchan != prev, "R8 alternation", rchan, !prev);
    end

    cmd = 4'b0100;
    w0 = we_cnt;
    pulse(30, 7, 0, "R7 command nonzero ignored");
    cmd = 4'b0000; cyc = 8'h03;
    pulse(30, 7, 0, "R7 timer nonzero ignored");
    cyc = '0;
    chk(we_cnt == w0, "R7 no result written", we_cnt, w0);

    busy = 1'b1;
    pulse(30, 9, 0, "R9 busy ignored");
    busy = 1'b0;
    chk(we_cnt == w0 && rdata == DW'(102), "R9 result kept", rdata, 102);

    en = 2'b01;
    w0 = we_cnt;
    adc = 12'h777;
    convst = 1'b1; step(30);
    convst = 1'b0; step(4);
    convst = 1'b1; step(3);
    convst = 1'b0; step(CV * TD + 8);
    chk(we_cnt == w0 + 1, "R11 one write per conversion", we_cnt, w0 + 1);
    chk(!pwr && !hold, "R11 back in shutdown", {pwr, hold}, 0);
    chk(rvalid == 1 && rdata == 12'h777, "R11 result valid", rdata, 12'h777);
    chk(res_q.size() == we_cnt, "R5 writes match model", we_cnt, res_q.size());

    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule